// File: doc/BRIEF.md
# Double-Buffered Serial Converter Front End

This block is the digital input stage of a 16-bit serial-input digital-to-analog converter. A host drives a slow serial clock, a data line and two active-low enables. One enable routes serial bits into an input shift register. The other copies that register into an output latch. The output latch drives the converter switches and is brought out here as a parallel word.

When both enables are low, the block runs in a through mode. Every shifted bit also lands in the output latch, so only two wires are needed. The most significant stage of the shift register is driven onto a serial output. This lets several devices be chained on one data stream. An active-low clear empties both stages to the two's-complement zero code, which is mid-scale.

The serial pins are asynchronous to the system clock `clk`. They pass through a synchronizer, and the block acts on the detected rising edge of the serial clock. The clear takes effect immediately and is released on a clock edge.

Top module: `sdac_front`

## Requirements
- R1: After the synchronous active-high `rst`, `dac_word_o` is 0x0000 and `sdo_o` is 0.
- R2: With `shift_en_n_i`=0 and `load_en_n_i`=1, each serial-clock low-to-high transition shifts the register left by one, with `sdi_i` entering bit 0. Words therefore arrive most significant bit first. `dac_word_o` does not change.
- R3: With `shift_en_n_i`=1 and `load_en_n_i`=0, a serial-clock rising edge copies the input register into `dac_word_o` and leaves the register unchanged. Two's-complement codes such as 0x7FFF (plus full scale) and 0x8000 (minus full scale) pass through unaltered.
- R4: With both enables high, a serial-clock rising edge changes neither the register nor `dac_word_o`.
- R5: While the serial clock stays at one level, changes on `sdi_i` and on the enables alter nothing.
- R6: With both enables low, a serial-clock rising edge shifts the register and loads the shifted value into `dac_word_o` on the same edge.
- R7: `clr_n_i` low forces the register and `dac_word_o` to 0x0000 without waiting for a clock edge. It overrides every other input while held. It is released on a `clk` edge, after which shifting resumes normally.
- R8: `sdo_o` always shows bit 15 of the input register. A word shifted in therefore starts to appear on `sdo_o` 16 serial clocks after it began, which supports daisy-chaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock; acts on its low-to-high transition |
| sdi_i | input | 1 | Serial data in, MSB first |
| shift_en_n_i | input | 1 | Shift enable, active low |
| load_en_n_i | input | 1 | Output latch enable, active low |
| clr_n_i | input | 1 | Clear, active low, asynchronous assertion |
| sdo_o | output | 1 | Serial data out (register MSB) |
| dac_word_o | output | 16 | Held output word, two's complement |

## Verification
On every `clk` edge, the checker ties each detected serial-clock edge to the decoded enable pair. It confirms that shift, load, hold and through each move the register and the output word exactly as the requirements state. It also confirms that nothing moves between edges and that both stages read zero while the clear is held. Only the bench scenarios can show end-to-end word ordering (MSB first), the 16-clock delay of a daisy chain, and the asynchronous effect of the clear between clock edges. The same holds for the behaviour of the full two's-complement codes after a load.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned SYNC_N = 2;

    // bit 1: latch enable active, bit 0: shift enable active
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_SHIFT = 2'b01,
        OP_LOAD  = 2'b10,
        OP_THRU  = 2'b11
    } op_e;

    typedef struct packed {
        logic sclk;
        logic sdi;
        logic shift_n;
        logic load_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, sdi: 1'b0, shift_n: 1'b1, load_n: 1'b1};

    function automatic op_e decode_op(input logic shift_n, input logic load_n);
        op_e res;
        case ({~load_n, ~shift_n})
            2'b01:   res = OP_SHIFT;
            2'b10:   res = OP_LOAD;
            2'b11:   res = OP_THRU;
            default: res = OP_IDLE;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync
    import sdac_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_N
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_i,
    output pins_t pins_o,
    output logic  rise_o
);
    pins_t [STAGES-1:0] stage_q;
    logic               sclk_prev_q;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (rst) stage_q <= {STAGES{PINS_IDLE}};
            else     stage_q <= pins_i;
        end
    end else begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage_q <= {STAGES{PINS_IDLE}};
            else     stage_q <= {stage_q[STAGES-2:0], pins_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b1;
        else     sclk_prev_q <= stage_q[STAGES-1].sclk;
    end

    assign pins_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1].sclk & ~sclk_prev_q;
endmodule

// File: rtl/sdac_clear_ctl.sv
module sdac_clear_ctl (
    input  logic clk,
    input  logic rst,
    input  logic clr_n_i,
    output logic hold_o
);
    logic [1:0] hold_q;

    always_ff @(posedge clk or negedge clr_n_i) begin
        if (!clr_n_i)  hold_q <= 2'b11;
        else if (rst)  hold_q <= 2'b00;
        else           hold_q <= {hold_q[0], 1'b0};
    end

    assign hold_o = hold_q[1];
endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n_i,
    input  logic         hold_i,
    input  logic         step_i,
    input  logic         sdi_i,
    output logic [W-1:0] sreg_o,
    output logic [W-1:0] next_o,
    output logic         sdo_o
);
    logic [W-1:0] sreg_q;

    assign next_o = {sreg_q[W-2:0], sdi_i};

    always_ff @(posedge clk or negedge clr_n_i) begin
        if (!clr_n_i)             sreg_q <= '0;
        else if (rst || hold_i)   sreg_q <= '0;
        else if (step_i)          sreg_q <= next_o;
    end

    assign sreg_o = sreg_q;
    assign sdo_o  = sreg_q[W-1];
endmodule

// File: rtl/sdac_out_latch.sv
module sdac_out_latch
    import sdac_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n_i,
    input  logic         hold_i,
    input  logic         rise_i,
    input  op_e          op_i,
    input  logic [W-1:0] sreg_i,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk or negedge clr_n_i) begin
        if (!clr_n_i)            word_q <= '0;
        else if (rst || hold_i)  word_q <= '0;
        else if (rise_i) begin
            case (op_i)
                OP_LOAD: word_q <= sreg_i;
                OP_THRU: word_q <= next_i;
                default: word_q <= word_q;
            endcase
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int unsigned WIDTH       = WORD_W,
    parameter int unsigned SYNC_STAGES = SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             shift_en_n_i,
    input  logic             load_en_n_i,
    input  logic             clr_n_i,
    output logic             sdo_o,
    output logic [WIDTH-1:0] dac_word_o
);
    pins_t            pins_raw;
    pins_t            pins_s;
    logic             sclk_rise;
    logic             clr_hold;
    logic             sdi_s;
    op_e              op;
    logic             shift_step;
    logic [WIDTH-1:0] sreg;
    logic [WIDTH-1:0] sreg_next;

    assign pins_raw = '{sclk: sclk_i, sdi: sdi_i, shift_n: shift_en_n_i, load_n: load_en_n_i};

    sdac_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_raw),
        .pins_o (pins_s),
        .rise_o (sclk_rise)
    );

    sdac_clear_ctl u_clr (
        .clk     (clk),
        .rst     (rst),
        .clr_n_i (clr_n_i),
        .hold_o  (clr_hold)
    );

    assign sdi_s      = pins_s.sdi;
    assign op         = decode_op(pins_s.shift_n, pins_s.load_n);
    assign shift_step = sclk_rise && (op == OP_SHIFT || op == OP_THRU);

    sdac_shift_reg #(.W(WIDTH)) u_sreg (
        .clk     (clk),
        .rst     (rst),
        .clr_n_i (clr_n_i),
        .hold_i  (clr_hold),
        .step_i  (shift_step),
        .sdi_i   (sdi_s),
        .sreg_o  (sreg),
        .next_o  (sreg_next),
        .sdo_o   (sdo_o)
    );

    sdac_out_latch #(.W(WIDTH)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr_n_i (clr_n_i),
        .hold_i  (clr_hold),
        .rise_i  (sclk_rise),
        .op_i    (op),
        .sreg_i  (sreg),
        .next_i  (sreg_next),
        .word_o  (dac_word_o)
    );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
    import sdac_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         hold,
    input logic         rise,
    input op_e          op,
    input logic         sdi_s,
    input logic [W-1:0] sreg,
    input logic [W-1:0] word,
    input logic         sdo
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> (word == '0 && sreg == '0));

    a_r2_shift_in_lsb: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_SHIFT) |=> sreg == {$past(sreg[W-2:0]), $past(sdi_s)});

    a_r2_shift_keeps_word: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_SHIFT) |=> $stable(word));

    a_r3_load_copy: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_LOAD) |=> (word == $past(sreg) && $stable(sreg)));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_IDLE) |=> ($stable(word) && $stable(sreg)));

    a_r5_no_edge_no_change: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        !rise |=> ($stable(word) && $stable(sreg)));

    a_r6_thru_same_edge: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_THRU) |=> word == sreg);

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        hold |-> (word == '0 && sreg == '0 && !sdo));

    a_r8_sdo_next_bit: assert property (@(posedge clk) disable iff (rst || !clr_n || hold)
        (rise && op == OP_SHIFT) |=> sdo == $past(sreg[W-2]));
endmodule

bind sdac_front sdac_front_chk #(.W(WIDTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n_i),
    .hold  (clr_hold),
    .rise  (sclk_rise),
    .op    (op),
    .sdi_s (sdi_s),
    .sreg  (sreg),
    .word  (dac_word_o),
    .sdo   (sdo_o)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        sh_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        sdo;
    logic [15:0] word;

    typedef struct {
        logic [15:0] word;
        logic        sdo;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] m_sr = '0;
    logic [15:0] m_word = '0;
    bit          in_clear = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    sdac_front u0 (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .sdi_i        (sdi),
        .shift_en_n_i (sh_n),
        .load_en_n_i  (ld_n),
        .clr_n_i      (clr_n),
        .sdo_o        (sdo),
        .dac_word_o   (word)
    );

    function automatic void compare(input item_t it);
        n_checks++;
        if (word !== it.word || sdo !== it.sdo) begin
            n_fail++;
            $display("FAIL %s: word=%h sdo=%b expected word=%h sdo=%b",
                     it.tag, word, sdo, it.word, it.sdo);
        end
    endfunction

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    task automatic expect_now(input string tag);
        item_t it;
        it.word = m_word;
        it.sdo  = m_sr[15];
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic pulse(input logic d, input logic s_n, input logic l_n);
        logic [15:0] nxt;
        @(negedge clk);
        sclk = 1'b0; sdi = d; sh_n = s_n; ld_n = l_n;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (5) @(negedge clk);
        if (!in_clear) begin
            nxt = {m_sr[14:0], d};
            if (!s_n && !l_n)     m_word = nxt;
            else if (s_n && !l_n) m_word = m_sr;
            if (!s_n)             m_sr = nxt;
        end
    endtask

    task automatic shift_word(input logic [15:0] w, input logic l_n, input string tag);
        for (int i = 15; i >= 0; i--) begin
            pulse(w[i], 1'b0, l_n);
            expect_now(tag);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        expect_now("R1 reset state");

        // R2/R8: shift a word, output held, sdo tracks MSB each step
        shift_word(16'hA5C3, 1'b1, "R2 R8 shift MSB first");
        // R3: load and reload
        pulse(1'b0, 1'b1, 1'b0);
        expect_now("R3 load A5C3");
        pulse(1'b1, 1'b1, 1'b0);
        expect_now("R3 reload keeps register");
        // R4: idle pulses
        pulse(1'b1, 1'b1, 1'b1);
        pulse(1'b0, 1'b1, 1'b1);
        expect_now("R4 idle no change");

        // R5: serial clock held high, enables wiggle
        @(negedge clk);
        sh_n = 1'b0; ld_n = 1'b0; sdi = 1'b1;
        repeat (6) @(negedge clk);
        sh_n = 1'b1; ld_n = 1'b0; sdi = 1'b0;
        repeat (6) @(negedge clk);
        expect_now("R5 clock held high");
        // serial clock held low, enables wiggle
        sclk = 1'b0;
        sh_n = 1'b0; ld_n = 1'b1; sdi = 1'b1;
        repeat (6) @(negedge clk);
        sh_n = 1'b0; ld_n = 1'b0;
        repeat (6) @(negedge clk);
        sh_n = 1'b1; ld_n = 1'b1;
        repeat (6) @(negedge clk);
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        expect_now("R5 clock held low");

        // R6: two-wire through mode, output follows every bit
        shift_word(16'h7FFF, 1'b0, "R6 through mode");
        // R3: minus full scale via shift then load
        shift_word(16'h8000, 1'b1, "R2 shift 8000");
        pulse(1'b0, 1'b1, 1'b0);
        expect_now("R3 load 8000");

        // R8: daisy chain, first word emerges on sdo during second word
        shift_word(16'h1234, 1'b1, "R8 chain word A");
        shift_word(16'h8001, 1'b1, "R8 chain word A on sdo");
        pulse(1'b0, 1'b1, 1'b0);
        expect_now("R8 chain load second word");

        // R7: asynchronous clear between clock edges
        @(negedge clk);
        #2;
        clr_n = 1'b0;
        #1;
        begin
            item_t it;
            it.word = 16'h0000; it.sdo = 1'b0; it.tag = "R7 async clear";
            compare(it);
        end
        in_clear = 1;
        m_sr = '0; m_word = '0;
        pulse(1'b1, 1'b0, 1'b0);
        expect_now("R7 clear overrides through");
        @(negedge clk);
        clr_n = 1'b1;
        in_clear = 0;
        repeat (4) @(negedge clk);
        expect_now("R7 released zero");
        pulse(1'b1, 1'b0, 1'b1);
        expect_now("R7 shift after release");
        pulse(1'b0, 1'b1, 1'b0);
        expect_now("R7 load after release");

        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule